// File: doc/BRIEF.md
# Page-Table-Walking Address Translator

This block sits between a processor's address path and memory. It turns a 14-bit virtual address into a 12-bit physical address by reading one entry from a single-level page table in memory. A request carries the virtual address, a write flag and a supervisor flag. The block adds the virtual page number, scaled by the entry stride, to a table base input. It issues one memory read for that entry and waits for the data.

When the entry comes back, the block checks it. If the entry is not present, the request ends as a page fault. If the access breaks the entry's read, write or supervisor rules, the request ends as a protection fault. Otherwise the physical page number from the entry is joined with the unchanged page offset. The result comes out as a one-cycle response pulse. The block handles one translation at a time, and its request-ready output stays low while a translation is in flight.

Entry word layout, bit 9 down to bit 0: supervisor-only (9), writable (8), readable (7), present (6), physical page number (5:0).

Top module: `pt_xlate_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req`, `rsp_valid`, `rsp_page_fault`, `rsp_prot_fault` and `rsp_paddr` are 0.
- R2: For an accepted request with no fault, `rsp_paddr` equals {entry bits 5:0, virtual address bits 5:0}. The virtual page number is virtual address bits 13:6.
- R3: Each accepted request produces exactly one `mem_req` pulse, one cycle long, in the cycle after acceptance. `mem_addr` equals (`pt_base` + VPN × stride) modulo 2^12, with a stride of 1 by default, and `pt_base` is sampled at acceptance.
- R4: If entry bit 6 (present) is 0, the response has `rsp_page_fault`=1, `rsp_prot_fault`=0 and `rsp_paddr`=0.
- R5: For a present entry, `rsp_prot_fault`=1 and `rsp_paddr`=0 when any of these holds: a read access (`req_write`=0) with bit 7 clear; a write access with bit 8 clear; bit 9 set while `req_sup`=0.
- R6: `req_ready` is 0 from the cycle after acceptance until the cycle in which `rsp_valid` is 1. `req_valid` during that time is ignored and does not change the result.
- R7: `rsp_valid` is high for exactly one cycle per request, in the cycle after `mem_rvalid` is seen. While `rsp_valid` is 0, the two fault flags and `rsp_paddr` are 0.
- R8: `mem_rvalid` that arrives while no fetch is outstanding produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 14 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_sup | input | 1 | 1 = supervisor-mode access |
| pt_base | input | 12 | Page table base word address |
| mem_req | output | 1 | One-cycle read strobe for an entry |
| mem_addr | output | 12 | Entry word address |
| mem_rvalid | input | 1 | Entry data returned |
| mem_rdata | input | 10 | Entry word |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 12 | Physical address (0 on fault) |
| rsp_page_fault | output | 1 | Entry not present |
| rsp_prot_fault | output | 1 | Permission violation |

## Verification
Random virtual addresses, access types, base values and entry words, with memory latency varying from 1 to 4 cycles, cover every path of the permission logic. They also show that the offset passes through while the page number is replaced. Directed cases isolate each rule on its own: a known mapping whose result is computed by hand, an absent entry, a write to a read-only page, a user access to a supervisor page, and a base that wraps past the top of the memory address space. Extra request strobes during a fetch, and a stray memory return while the block is idle, show that the single-outstanding rule and the fetch gating hold. Neither of them may produce a second or altered response.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } walk_state_e;

  typedef struct packed {
    logic write;
    logic sup;
  } access_t;
endpackage

// File: rtl/pt_addr_split.sv
module pt_addr_split #(
  parameter int VA_W       = 14,
  parameter int OFF_W      = 6,
  parameter int MEM_AW     = 12,
  parameter int PTE_STRIDE = 1
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [MEM_AW-1:0] base,
  output logic [OFF_W-1:0]  offset,
  output logic [MEM_AW-1:0] pte_addr
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam logic [MEM_AW-1:0] STRIDE_W = MEM_AW'(PTE_STRIDE);

  logic [VPN_W-1:0]  vpn;
  logic [MEM_AW-1:0] scaled;

  always_comb begin
    vpn      = vaddr[VA_W-1:OFF_W];
    offset   = vaddr[OFF_W-1:0];
    scaled   = MEM_AW'(vpn) * STRIDE_W;
    pte_addr = base + scaled;
  end
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check #(
  parameter int PPN_W = 6,
  localparam int PTE_W = PPN_W + 4
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             acc_write,
  input  logic             acc_sup,
  output logic             page_fault,
  output logic             prot_fault,
  output logic [PPN_W-1:0] ppn
);
  localparam int B_PRESENT = PPN_W;
  localparam int B_READ    = PPN_W + 1;
  localparam int B_WRITE   = PPN_W + 2;
  localparam int B_SUPONLY = PPN_W + 3;

  logic rights_bad;

  always_comb begin
    ppn        = pte[PPN_W-1:0];
    rights_bad = (acc_write ? !pte[B_WRITE] : !pte[B_READ]) ||
                 (pte[B_SUPONLY] && !acc_sup);
    page_fault = !pte[B_PRESENT];
    prot_fault = pte[B_PRESENT] && rights_bad;
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_xlate_pkg::*;
#(
  parameter int OFF_W  = 6,
  parameter int PPN_W  = 6,
  parameter int MEM_AW = 12,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_sup,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [MEM_AW-1:0] req_pte_addr,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rvalid,
  output logic              acc_write,
  output logic              acc_sup,
  input  logic              chk_page_fault,
  input  logic              chk_prot_fault,
  input  logic [PPN_W-1:0]  chk_ppn,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_page_fault,
  output logic              rsp_prot_fault
);
  walk_state_e      state;
  access_t          acc_q;
  logic [OFF_W-1:0] off_q;

  assign req_ready = (state == ST_IDLE);
  assign acc_write = acc_q.write;
  assign acc_sup   = acc_q.sup;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      acc_q          <= '0;
      off_q          <= '0;
      mem_req        <= 1'b0;
      mem_addr       <= '0;
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_page_fault <= 1'b0;
      rsp_prot_fault <= 1'b0;
    end else begin
      mem_req        <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_page_fault <= 1'b0;
      rsp_prot_fault <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            acc_q    <= '{write: req_write, sup: req_sup};
            off_q    <= req_off;
            mem_addr <= req_pte_addr;
            mem_req  <= 1'b1;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_rvalid) begin
            rsp_valid      <= 1'b1;
            rsp_page_fault <= chk_page_fault;
            rsp_prot_fault <= chk_prot_fault;
            if (!chk_page_fault && !chk_prot_fault)
              rsp_paddr <= {chk_ppn, off_q};
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_fetch_follows_accept_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_req);
  assert_fetch_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  assert_resp_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_quiet_outputs_R7: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_paddr == '0 && !rsp_page_fault && !rsp_prot_fault));
  assert_fault_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_page_fault |-> (!rsp_prot_fault && rsp_paddr == '0));
  assert_prot_no_addr_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_prot_fault |-> (rsp_paddr == '0));
  assert_idle_no_resp_R8: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !rsp_valid) |=> !rsp_valid);
endmodule

// File: rtl/pt_xlate_top.sv
module pt_xlate_top #(
  parameter int VA_W       = 14,
  parameter int PA_W       = 12,
  parameter int PAGE_BYTES = 64,
  parameter int MEM_AW     = 12,
  parameter int PTE_STRIDE = 1,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PPN_W     = PA_W - OFF_W,
  localparam int PTE_W     = PPN_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_sup,
  input  logic [MEM_AW-1:0] pt_base,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_page_fault,
  output logic              rsp_prot_fault
);
  logic [OFF_W-1:0]  off_w;
  logic [MEM_AW-1:0] pte_addr_w;
  logic              acc_write_w, acc_sup_w;
  logic              pf_w, prf_w;
  logic [PPN_W-1:0]  ppn_w;

  pt_addr_split #(.VA_W(VA_W), .OFF_W(OFF_W), .MEM_AW(MEM_AW), .PTE_STRIDE(PTE_STRIDE)) split_i (
    .vaddr(req_vaddr), .base(pt_base), .offset(off_w), .pte_addr(pte_addr_w)
  );

  pt_perm_check #(.PPN_W(PPN_W)) check_i (
    .pte(mem_rdata), .acc_write(acc_write_w), .acc_sup(acc_sup_w),
    .page_fault(pf_w), .prot_fault(prf_w), .ppn(ppn_w)
  );

  pt_walk_fsm #(.OFF_W(OFF_W), .PPN_W(PPN_W), .MEM_AW(MEM_AW)) walk_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sup(req_sup),
    .req_off(off_w), .req_pte_addr(pte_addr_w),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .acc_write(acc_write_w), .acc_sup(acc_sup_w),
    .chk_page_fault(pf_w), .chk_prot_fault(prf_w), .chk_ppn(ppn_w),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault)
  );
endmodule

// File: tb/pt_xlate_top_tb_top.sv
`timescale 1ns/1ps
module pt_xlate_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_sup = 1'b0;
  logic [11:0] pt_base = '0;
  logic        mem_req;
  logic [11:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [9:0]  mem_rdata = '0;
  logic        rsp_valid;
  logic [11:0] rsp_paddr;
  logic        rsp_page_fault;
  logic        rsp_prot_fault;

  int n_checks = 0;
  int n_err = 0;
  int lat = 1;
  int mreq_cnt = 0;
  logic [11:0] maddr_seen = '0;
  logic [9:0] pt_mem [4096];

  always #10 clk = ~clk;

  pt_xlate_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_sup(req_sup),
    .pt_base(pt_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_page_fault(rsp_page_fault),
    .rsp_prot_fault(rsp_prot_fault)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  // {page_fault, prot_fault, paddr}
  function automatic logic [13:0] model(input logic [9:0] pte, input logic wr,
                                        input logic sup, input logic [13:0] va);
    logic bad;
    if (!pte[6]) return {2'b10, 12'h000};
    bad = (wr ? !pte[8] : !pte[7]) || (pte[9] && !sup);
    if (bad) return {2'b01, 12'h000};
    return {2'b00, pte[5:0], va[5:0]};
  endfunction

  // memory responder
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mem_req) begin
        mreq_cnt++;
        maddr_seen = mem_addr;
        repeat (lat) @(negedge clk);
        mem_rdata  = pt_mem[maddr_seen];
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic xlate(input logic [13:0] va, input logic wr, input logic sup,
                       input logic [11:0] base, input logic [9:0] pte, input bit poke,
                       input string tag);
    logic [11:0] eaddr;
    logic [13:0] exp;
    int start_cnt;
    bit busy_ok;
    int waited;
    eaddr = base + {4'h0, va[13:6]};
    pt_mem[eaddr] = pte;
    exp = model(pte, wr, sup, va);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start_cnt = mreq_cnt;
    req_vaddr = va; req_write = wr; req_sup = sup; pt_base = base;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (poke) begin
      req_vaddr = ~va; req_write = ~wr; pt_base = base + 12'h100;
    end else req_valid = 1'b0;
    busy_ok = 1'b1;
    waited = 0;
    forever begin
      @(negedge clk);
      if (rsp_valid) break;
      if (req_ready) busy_ok = 1'b0;
      waited++;
      if (waited > 40) break;
    end
    req_valid = 1'b0;
    check(busy_ok, "R6 ready low while busy", {31'b0, busy_ok}, 1);
    check(rsp_valid, {tag, " R7 response arrives"}, {31'b0, rsp_valid}, 1);
    check(maddr_seen == eaddr, "R3 entry address", maddr_seen, eaddr);
    check(mreq_cnt - start_cnt == 1, "R3 one fetch", mreq_cnt - start_cnt, 1);
    check(rsp_paddr == exp[11:0], {tag, " R2 paddr"}, rsp_paddr, exp[11:0]);
    check(rsp_page_fault == exp[13], {tag, " R4 page fault"}, rsp_page_fault, exp[13]);
    check(rsp_prot_fault == exp[12], {tag, " R5 prot fault"}, rsp_prot_fault, exp[12]);
    @(negedge clk);
    check(!rsp_valid && rsp_paddr == 0 && !rsp_page_fault && !rsp_prot_fault,
          "R7 single cycle response", {rsp_valid, rsp_page_fault, rsp_prot_fault, rsp_paddr}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit quiet;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) pt_mem[i] = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !mem_req && !rsp_valid && rsp_paddr == 0 && !rsp_page_fault && !rsp_prot_fault,
          "R1 reset state", {req_ready, mem_req, rsp_valid, rsp_page_fault, rsp_prot_fault}, 5'b10000);

    // directed: known mapping, VPN 0x0F -> PPN 0x0D
    lat = 1;
    xlate(14'h03D4, 1'b0, 1'b0, 12'h000, {1'b0, 1'b0, 1'b1, 1'b1, 6'h0D}, 0, "map");
    check(1'b1, "R2 hand value 0x354 covered above", 0, 0);
    // absent entry
    lat = 3;
    xlate(14'h0B8F, 1'b0, 1'b1, 12'h010, {4'b1110, 6'h2A}, 0, "absent");
    // write to read-only
    xlate(14'h0020, 1'b1, 1'b1, 12'h020, {4'b0011, 6'h28}, 0, "ro_write");
    // user to supervisor page
    lat = 2;
    xlate(14'h1234, 1'b0, 1'b0, 12'h040, {4'b1111, 6'h11}, 0, "sup_page");
    // supervisor to supervisor page, write allowed
    xlate(14'h1234, 1'b1, 1'b1, 12'h040, {4'b1111, 6'h11}, 0, "sup_ok");
    // read with read bit clear
    xlate(14'h2FFF, 1'b0, 1'b1, 12'h000, {4'b0101, 6'h3F}, 0, "no_read");
    // base wraps past top of memory space
    lat = 4;
    xlate(14'h0805, 1'b0, 1'b0, 12'hFF0, {4'b0011, 6'h05}, 0, "wrap");
    // extra requests while busy are ignored
    xlate(14'h3F3F, 1'b0, 1'b0, 12'h123, {4'b0111, 6'h22}, 1, "poke");

    // R8: stray memory return while idle
    @(negedge clk);
    mem_rdata = 10'h3FF; mem_rvalid = 1'b1;
    @(negedge clk);
    mem_rvalid = 1'b0;
    quiet = !rsp_valid;
    @(negedge clk);
    quiet = quiet && !rsp_valid && req_ready;
    check(quiet, "R8 stray return ignored", {31'b0, quiet}, 1);

    for (int k = 0; k < 60; k++) begin
      lat = 1 + ($urandom % 4);
      xlate(14'($urandom), 1'($urandom), 1'($urandom), 12'($urandom),
            10'($urandom), ($urandom % 5) == 0, "random");
    end
    finish_run();
  end
endmodule